// File: doc/BRIEF.md
# Mode-Gated Interrupt Merge Unit

This block gathers three families of event flags (four from the transmit path, eight from the receive path covering two receive channels, and one that marks the oscillator as started after power-down) and drives a single shared interrupt pin. Each family has a sticky status register and an enable register, and both are reached over a small synchronous register bus. A status bit is set by its event pulse whether or not it is enabled, so firmware can poll for events instead of using the pin. Reading a status register clears it.

Two mode inputs, one for transmit and one for receive, gate the families. While transmit mode is on, the receive family cannot raise the pin. While receive mode is on, the transmit family cannot. The wake family is never gated. Gating touches only the pin request, so enable registers keep their values across mode changes. A two-bit pin configuration field selects one of four drive styles, giving the pin level and the tri-state enable.

The register bus is plain control. A write or a read takes one cycle with no handshake. Read data is combinational from the current register state. A clear-on-read takes effect at the same clock edge that ends the read cycle.

Top module: `irq_merge_unit`

## Requirements
- R1: After reset the enable registers read 0, the pin configuration (address 0x05) reads 0x01, the transmit and receive status registers read 0, and the wake status register reads 0x01. The pin idles at level 0 with the output enable high.
- R2: An event pulse on input bit i sets status bit i of its family at the next clock edge. The bit stays set until its status register is read, whatever the enable and mode settings.
- R3: A read of a status register returns its current contents and clears the whole register at the end of the read cycle. Other families are left untouched. Addresses: receive status 0x08, transmit status 0x0E, wake status 0x1D (bit 0).
- R4: An event that arrives in the same cycle as a read of its status register is held in that register after the read.
- R5: The pin request is active when any bit of status AND enable is set in an ungated family. Enable addresses: receive 0x07 (8 bits), transmit 0x0D (bits 3:0), wake 0x1C (bit 0).
- R6: When the transmit mode input is high, the receive family is gated off. When the receive mode input is high, the transmit family is gated off. The wake family is never gated.
- R7: Enable register contents read back unchanged across any sequence of mode input changes.
- R8: The configuration field (address 0x05, bits 1:0) maps to the pin as {level, output enable}. With the request active: 11 gives {1,1}, 10 gives {0,1}, 01 gives {1,1}, 00 gives {0,1}. With the request idle: 11 gives {0,0}, 10 gives {0,0}, 01 gives {0,1}, 00 gives {1,1}.
- R9: Writes to status addresses have no effect. Unused bits of the configuration register read 0, and unmapped addresses read 0.
- R10: Only bit 0 of the wake enable register and bits 3:0 of the transmit enable register are stored. The other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_evt | input | 4 | Transmit event pulses, one cycle each |
| rx_evt | input | 8 | Receive event pulses (channel A bits 3:0, channel B bits 7:4) |
| wake_evt | input | 1 | Oscillator-started pulse |
| tx_mode | input | 1 | Transmit mode active, gates the receive family |
| rx_mode | input | 1 | Receive mode active, gates the transmit family |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; clears status registers |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from current state |
| irq_out | output | 1 | Interrupt pin level |
| irq_oe | output | 1 | Interrupt pin output enable (0 = high-Z) |

## Verification
The directed part sets single events with the enables off to show that status is set apart from the pin. It then lines up an event with a read of the same register to tell a lost event from a held one. Masking is tried in each combination of the two mode inputs, with pending transmit, receive and wake sources, so that family gating can be told apart from clearing of the enables. All four drive styles are swept with the request both high and low. The random part mixes sparse events, mode toggles and bus accesses over every mapped and some unmapped addresses, and compares each read and each pin state with a bench model.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_PIN_CFG = 6'h05;
  localparam logic [ADDR_W-1:0] A_RX_EN   = 6'h07;
  localparam logic [ADDR_W-1:0] A_RX_ST   = 6'h08;
  localparam logic [ADDR_W-1:0] A_TX_EN   = 6'h0D;
  localparam logic [ADDR_W-1:0] A_TX_ST   = 6'h0E;
  localparam logic [ADDR_W-1:0] A_WK_EN   = 6'h1C;
  localparam logic [ADDR_W-1:0] A_WK_ST   = 6'h1D;

  // pin drive styles, encoding fixed by the configuration field
  typedef enum logic [1:0] {
    DRV_PUSH_LOW  = 2'b00,  // active 0, idle 1, always driven
    DRV_PUSH_HIGH = 2'b01,  // active 1, idle 0, always driven
    DRV_SINK      = 2'b10,  // active 0, idle released
    DRV_SOURCE    = 2'b11   // active 1, idle released
  } drv_style_e;

  localparam drv_style_e DRV_RESET = DRV_PUSH_HIGH;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int             W       = 4,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr,
  output logic [W-1:0] stat
);
  // sticky flags; a pulse in the clearing cycle survives the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= RST_VAL;
    else        stat <= (clr ? '0 : stat) | evt;
  end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_merge_pkg::*;
#(
  parameter int TX_N = 4,
  parameter int RX_N = 8,
  parameter int WK_N = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [TX_N-1:0]   tx_stat,
  input  logic [RX_N-1:0]   rx_stat,
  input  logic [WK_N-1:0]   wake_stat,
  output logic [TX_N-1:0]   tx_en,
  output logic [RX_N-1:0]   rx_en,
  output logic [WK_N-1:0]   wake_en,
  output drv_style_e        drv_style,
  output logic              tx_clr,
  output logic              rx_clr,
  output logic              wake_clr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en     <= '0;
      rx_en     <= '0;
      wake_en   <= '0;
      drv_style <= DRV_RESET;
    end else if (reg_wr) begin
      case (reg_addr)
        A_TX_EN:   tx_en     <= reg_wdata[TX_N-1:0];
        A_RX_EN:   rx_en     <= reg_wdata[RX_N-1:0];
        A_WK_EN:   wake_en   <= reg_wdata[WK_N-1:0];
        A_PIN_CFG: drv_style <= drv_style_e'(reg_wdata[1:0]);
        default:   ;
      endcase
    end
  end

  assign tx_clr   = reg_rd && (reg_addr == A_TX_ST);
  assign rx_clr   = reg_rd && (reg_addr == A_RX_ST);
  assign wake_clr = reg_rd && (reg_addr == A_WK_ST);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_TX_EN:   reg_rdata[TX_N-1:0] = tx_en;
      A_TX_ST:   reg_rdata[TX_N-1:0] = tx_stat;
      A_RX_EN:   reg_rdata[RX_N-1:0] = rx_en;
      A_RX_ST:   reg_rdata[RX_N-1:0] = rx_stat;
      A_WK_EN:   reg_rdata[WK_N-1:0] = wake_en;
      A_WK_ST:   reg_rdata[WK_N-1:0] = wake_stat;
      A_PIN_CFG: reg_rdata[1:0]      = drv_style;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive
  import irq_merge_pkg::*;
(
  input  drv_style_e style,
  input  logic       req,
  output logic       pin_lvl,
  output logic       pin_oe
);
  always_comb begin
    case (style)
      DRV_PUSH_LOW:  begin pin_lvl = ~req; pin_oe = 1'b1; end
      DRV_PUSH_HIGH: begin pin_lvl = req;  pin_oe = 1'b1; end
      DRV_SINK:      begin pin_lvl = 1'b0; pin_oe = req;  end
      DRV_SOURCE:    begin pin_lvl = req;  pin_oe = req;  end
      default:       begin pin_lvl = req;  pin_oe = 1'b1; end
    endcase
  end
endmodule

// File: rtl/irq_merge_unit.sv
module irq_merge_unit
  import irq_merge_pkg::*;
#(
  parameter int TX_N = 4,
  parameter int RX_N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TX_N-1:0]   tx_evt,
  input  logic [RX_N-1:0]   rx_evt,
  input  logic              wake_evt,
  input  logic              tx_mode,
  input  logic              rx_mode,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_out,
  output logic              irq_oe
);
  localparam int WK_N = 1;

  logic [TX_N-1:0] tx_stat, tx_en;
  logic [RX_N-1:0] rx_stat, rx_en;
  logic [WK_N-1:0] wake_stat, wake_en;
  logic            tx_clr, rx_clr, wake_clr;
  drv_style_e      drv_style;
  logic            tx_hit, rx_hit, wk_hit, irq_req;

  irq_status_bank #(.W(TX_N), .RST_VAL('0)) u_tx_bank (
    .clk(clk), .rst_n(rst_n), .evt(tx_evt), .clr(tx_clr), .stat(tx_stat));

  irq_status_bank #(.W(RX_N), .RST_VAL('0)) u_rx_bank (
    .clk(clk), .rst_n(rst_n), .evt(rx_evt), .clr(rx_clr), .stat(rx_stat));

  // wake flag starts set: the oscillator is already running out of reset
  irq_status_bank #(.W(WK_N), .RST_VAL('1)) u_wk_bank (
    .clk(clk), .rst_n(rst_n), .evt(wake_evt), .clr(wake_clr), .stat(wake_stat));

  irq_regfile #(.TX_N(TX_N), .RX_N(RX_N), .WK_N(WK_N)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_stat(tx_stat), .rx_stat(rx_stat), .wake_stat(wake_stat),
    .tx_en(tx_en), .rx_en(rx_en), .wake_en(wake_en), .drv_style(drv_style),
    .tx_clr(tx_clr), .rx_clr(rx_clr), .wake_clr(wake_clr));

  // direction gating acts on the request only; enables are untouched
  assign tx_hit  = (|(tx_stat & tx_en)) & ~rx_mode;
  assign rx_hit  = (|(rx_stat & rx_en)) & ~tx_mode;
  assign wk_hit  = |(wake_stat & wake_en);
  assign irq_req = tx_hit | rx_hit | wk_hit;

  irq_pin_drive u_pin (
    .style(drv_style), .req(irq_req), .pin_lvl(irq_out), .pin_oe(irq_oe));
endmodule

// File: rtl/irq_merge_chk.sv
module irq_merge_chk
  import irq_merge_pkg::*;
#(
  parameter int TX_N = 4,
  parameter int RX_N = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TX_N-1:0]   tx_evt,
  input logic [RX_N-1:0]   rx_evt,
  input logic              tx_mode,
  input logic              rx_mode,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [TX_N-1:0]   tx_stat,
  input logic [RX_N-1:0]   rx_stat,
  input logic [RX_N-1:0]   rx_en,
  input logic              wk_hit,
  input logic              irq_req,
  input logic [1:0]        drv_style,
  input logic              irq_out,
  input logic              irq_oe
);
  // R2
  tx_evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tx_evt) |=> ((tx_stat & $past(tx_evt)) == $past(tx_evt)));

  // R4
  rx_evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_evt) |=> ((rx_stat & $past(rx_evt)) == $past(rx_evt)));

  // R2
  rx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_addr == A_RX_ST) |=> ((rx_stat & $past(rx_stat)) == $past(rx_stat)));

  // R3
  tx_rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_TX_ST && tx_evt == '0) |=> (tx_stat == '0));

  // R6
  both_modes_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && rx_mode && !wk_hit) |-> !irq_req);

  // R7
  rx_en_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_RX_EN) |=> $stable(rx_en));

  // R8
  push_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_style == 2'b00 || drv_style == 2'b01) |-> irq_oe);

  // R8
  sink_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_style == 2'b10) |-> !irq_out);
endmodule

bind irq_merge_unit irq_merge_chk #(.TX_N(TX_N), .RX_N(RX_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_evt(tx_evt), .rx_evt(rx_evt),
  .tx_mode(tx_mode), .rx_mode(rx_mode), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .tx_stat(tx_stat), .rx_stat(rx_stat), .rx_en(rx_en),
  .wk_hit(wk_hit), .irq_req(irq_req), .drv_style(drv_style),
  .irq_out(irq_out), .irq_oe(irq_oe));

// File: tb/sim_irq_merge_unit.sv
module sim_irq_merge_unit;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] tx_evt;
  logic [7:0] rx_evt;
  logic       wake_evt, tx_mode, rx_mode, reg_wr, reg_rd;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq_out, irq_oe;

  always #(CLK_NS/2) clk = ~clk;

  irq_merge_unit u0 (
    .clk(clk), .rst_n(rst_n), .tx_evt(tx_evt), .rx_evt(rx_evt),
    .wake_evt(wake_evt), .tx_mode(tx_mode), .rx_mode(rx_mode),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out), .irq_oe(irq_oe));

  int total = 0;
  int bad   = 0;

  // bench model
  logic [3:0] m_txen, m_txst;
  logic [7:0] m_rxen, m_rxst;
  logic       m_wken, m_wkst;
  logic [1:0] m_sty;
  logic       cur_tm, cur_rm;

  function automatic logic [7:0] m_read(input logic [5:0] a);
    case (a)
      6'h05:   return {6'b0, m_sty};
      6'h07:   return m_rxen;
      6'h08:   return m_rxst;
      6'h0D:   return {4'b0, m_txen};
      6'h0E:   return {4'b0, m_txst};
      6'h1C:   return {7'b0, m_wken};
      6'h1D:   return {7'b0, m_wkst};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic m_req(input logic tm, input logic rm);
    return ((|(m_txst & m_txen)) && !rm) || ((|(m_rxst & m_rxen)) && !tm) || (m_wkst && m_wken);
  endfunction

  // {level, oe}
  function automatic logic [1:0] m_pin(input logic [1:0] sty, input logic rq);
    case (sty)
      2'b11:   return rq ? 2'b11 : 2'b00;
      2'b10:   return rq ? 2'b01 : 2'b00;
      2'b01:   return rq ? 2'b11 : 2'b01;
      default: return rq ? 2'b01 : 2'b11;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // called at a falling edge; drives, checks, updates model, waits one cycle
  task automatic step(input logic [3:0] te, input logic [7:0] re, input logic we,
                      input int op, input logic [5:0] a, input logic [7:0] d, input string tag);
    tx_evt = te; rx_evt = re; wake_evt = we;
    tx_mode = cur_tm; rx_mode = cur_rm;
    reg_wr = (op == 1); reg_rd = (op == 2); reg_addr = a; reg_wdata = d;
    #1;
    check(tag, "pin", {6'b0, irq_out, irq_oe}, {6'b0, m_pin(m_sty, m_req(cur_tm, cur_rm))});
    if (op == 2) check(tag, "rdata", reg_rdata, m_read(a));
    if (op == 1) begin
      case (a)
        6'h05: m_sty  = d[1:0];
        6'h07: m_rxen = d;
        6'h0D: m_txen = d[3:0];
        6'h1C: m_wken = d[0];
        default: ;
      endcase
    end
    m_txst = ((op == 2 && a == 6'h0E) ? 4'h0 : m_txst) | te;
    m_rxst = ((op == 2 && a == 6'h08) ? 8'h00 : m_rxst) | re;
    m_wkst = ((op == 2 && a == 6'h1D) ? 1'b0 : m_wkst) | we;
    @(negedge clk);
  endtask

  task automatic idle(input string tag);            step(4'h0, 8'h00, 1'b0, 0, 6'h00, 8'h00, tag); endtask
  task automatic wr(input logic [5:0] a, input logic [7:0] d, input string tag); step(4'h0, 8'h00, 1'b0, 1, a, d, tag); endtask
  task automatic rd(input logic [5:0] a, input string tag); step(4'h0, 8'h00, 1'b0, 2, a, 8'h00, tag); endtask

  initial begin
    #(CLK_NS * 200000);
    total++; bad++;
    $display("FAIL watchdog expired R1 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [5:0] addrs [9];
    addrs = '{6'h05, 6'h07, 6'h08, 6'h0D, 6'h0E, 6'h1C, 6'h1D, 6'h00, 6'h3F};
    rst_n = 1'b0;
    tx_evt = '0; rx_evt = '0; wake_evt = 1'b0; tx_mode = 1'b0; rx_mode = 1'b0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    m_txen = '0; m_txst = '0; m_rxen = '0; m_rxst = '0;
    m_wken = 1'b0; m_wkst = 1'b1; m_sty = 2'b01; cur_tm = 1'b0; cur_rm = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(6'h05, "R1"); rd(6'h0D, "R1"); rd(6'h07, "R1"); rd(6'h08, "R1");
    rd(6'h1C, "R1"); rd(6'h1D, "R1");
    // R3: wake status cleared by the read above
    rd(6'h1D, "R3");

    // R2: status set with enable off, pin stays idle
    step(4'b0101, 8'h00, 1'b0, 0, 6'h00, 8'h00, "R2");
    idle("R2");
    rd(6'h0E, "R2");
    rd(6'h0E, "R3");

    // R4: event collides with read of its register
    step(4'b0001, 8'h00, 1'b0, 0, 6'h00, 8'h00, "R4");
    step(4'b0010, 8'h00, 1'b0, 2, 6'h0E, 8'h00, "R4");
    rd(6'h0E, "R4");
    step(4'h0, 8'h90, 1'b0, 2, 6'h08, 8'h00, "R4");
    rd(6'h08, "R4");

    // R5: enable a pending source
    step(4'b1000, 8'h00, 1'b0, 0, 6'h00, 8'h00, "R5");
    wr(6'h0D, 8'h08, "R5");
    idle("R5");

    // R6: gating per mode
    cur_rm = 1'b1; idle("R6");
    cur_rm = 1'b0; cur_tm = 1'b1; idle("R6");
    step(4'h0, 8'h04, 1'b0, 1, 6'h07, 8'h04, "R6");
    idle("R6");
    cur_tm = 1'b0; idle("R6");
    cur_tm = 1'b1; cur_rm = 1'b1; idle("R6");
    step(4'h0, 8'h00, 1'b1, 1, 6'h1C, 8'h01, "R6");
    idle("R6");
    rd(6'h1D, "R6");
    idle("R6");
    cur_tm = 1'b0; cur_rm = 1'b0;
    rd(6'h0E, "R6"); rd(6'h08, "R6"); idle("R6");

    // R7: enables survive mode changes
    cur_tm = 1'b1; wr(6'h07, 8'hA5, "R7");
    cur_tm = 1'b0; cur_rm = 1'b1; idle("R7");
    cur_tm = 1'b1; idle("R7");
    cur_tm = 1'b0; cur_rm = 1'b0;
    rd(6'h07, "R7"); rd(6'h0D, "R7"); rd(6'h1C, "R7");

    // R8: every drive style, request high then low
    for (int s = 0; s < 4; s++) begin
      wr(6'h05, 8'(s), "R8");
      step(4'b1000, 8'h00, 1'b0, 0, 6'h00, 8'h00, "R8");
      idle("R8");
      rd(6'h0E, "R8");
      idle("R8");
    end
    wr(6'h05, 8'h01, "R8");

    // R9: read-only and unmapped
    step(4'b0010, 8'h00, 1'b0, 0, 6'h00, 8'h00, "R9");
    wr(6'h0E, 8'hFF, "R9"); rd(6'h0E, "R9");
    wr(6'h08, 8'hFF, "R9"); rd(6'h08, "R9");
    wr(6'h1D, 8'hFF, "R9"); rd(6'h1D, "R9");
    wr(6'h05, 8'hFE, "R9"); rd(6'h05, "R9");
    wr(6'h3F, 8'hFF, "R9"); rd(6'h3F, "R9");
    wr(6'h05, 8'h01, "R9");

    // R10: narrow enable registers
    wr(6'h1C, 8'hFE, "R10"); rd(6'h1C, "R10");
    wr(6'h0D, 8'hF3, "R10"); rd(6'h0D, "R10");

    // random mix, checked against the model
    void'($urandom(32'd4711));
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] te; logic [7:0] re; logic we; int op; logic [5:0] a;
      te = (($urandom % 6) == 0) ? 4'($urandom) : 4'h0;
      re = (($urandom % 6) == 0) ? 8'($urandom) : 8'h00;
      we = (($urandom % 20) == 0);
      if (($urandom % 8) == 0) cur_tm = 1'($urandom);
      if (($urandom % 8) == 0) cur_rm = 1'($urandom);
      op = int'($urandom % 3);
      a  = addrs[$urandom % 9];
      step(te, re, we, op, a, 8'($urandom), "R5");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule